// File: doc/BRIEF.md
# Vectored Interrupt Manager with Phantom Slot

This block collects a bank of level-sensitive interrupt request lines and splits them into two classes: a fast class that drives the core's FIQ request and a normal class that drives its IRQ request. In each class it picks the pending channel with the lowest number. It reports that channel as an index and as a handler address taken from a small internal vector RAM. Software programs the vector RAM, the per-channel enable mask and the per-channel class-select mask through a simple word-addressed register bus. Bus reads are combinational and bus writes take effect at the clock edge.

Channel 0 is the non-maskable source. It always belongs to the fast class and ignores its enable bit. RAM slot 0 holds the phantom handler address, which is reported whenever a class has nothing pending. After reset, the first write to slot 0 is also copied into both vector output registers. A request that was already pending before the RAM was programmed can therefore end up pointing at the phantom handler. This behaviour is reproduced on purpose.

Top module: `intr_vector_mgr`

Register word addresses: 0 fast index, 1 normal index, 2 fast vector, 3 normal vector, 4 enable mask, 5 class mask. RAM slot k sits at word address `RAM_BASE + k` (default 64).

## Requirements
- R1: While reset is low and after it is released, both indices, both vectors, both requests, the enable mask and the class mask (apart from its bit 0) read 0, and every vector RAM slot holds 0.
- R2: Channel 0 is always handled in the fast class, whatever its enable bit and class bit hold. When it is requested, the fast index becomes 1 two clock edges after the request is sampled high.
- R3: Each index reads channel number plus one for the winning channel, and 0 when its class has no pending channel. The index never exceeds NUM_CH.
- R4: Within a class, the lowest-numbered pending channel wins.
- R5: For channels 1 and up, class-mask bit n = 1 selects the fast class and 0 selects the normal class. Bit 0 of the class mask always reads 1. A channel never appears in both indices.
- R6: For channels 1 and up, enable bit n = 0 removes channel n from arbitration.
- R7: At the edge where a class's index changes, its vector register loads RAM slot (new index). This is slot 0, the phantom address, when the index becomes 0, and the RAM is used even if it was never written. While the index is unchanged, the vector register holds its value.
- R8: Only the first write to RAM slot 0 after each reset also loads the written value into both vector registers, unless that class's index changes at the same edge. Later writes to slot 0 change only the RAM.
- R9: A RAM write at the same edge as an index change is seen by the vector load at that edge.
- R10: The fast request output is 1 exactly when the fast index is nonzero. The normal request output is 1 exactly when the normal index is nonzero.
- R11: Bus reads of the index, vector, mask and RAM addresses return the current register or slot contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqIn | input | NUM_CH | Interrupt request lines, level sensitive |
| busWrEn | input | 1 | Register bus write strobe |
| busAddr | input | ADDR_W | Register bus word address |
| busWrData | input | DATA_W | Register bus write data |
| busRdData | output | DATA_W | Register bus read data (combinational) |
| fiqReq | output | 1 | Fast-class request to the core |
| irqReq | output | 1 | Normal-class request to the core |
| fiqIndex | output | IDX_W | Fast-class winning channel plus one, 0 if none |
| irqIndex | output | IDX_W | Normal-class winning channel plus one, 0 if none |
| fiqVector | output | DATA_W | Fast-class handler address |
| irqVector | output | DATA_W | Normal-class handler address |

## Verification
A stale or wrong vector register shows up at the vector ports at the second edge after a request changes, because the index and the vector move at the same edge. A vector that differs from the RAM slot named by the index points to a bad load or a missed reload. A wrong first-write flag shows up as soon as slot 0 is written: either the vectors fail to switch to the phantom value on the first write, or they switch again on a later write. Arbitration and class errors show up at the index ports two edges after the request pattern changes.

// File: rtl/ivm_pkg.sv
package ivm_pkg;

  // Control-to-datapath strobes, valid for one cycle
  typedef struct packed {
    logic ramWe;        // write bus data into the addressed RAM slot
    logic phantomLoad;  // first write to slot 0 since reset
    logic loadFiq;      // fast index changes at this edge
    logic loadIrq;      // normal index changes at this edge
  } ivm_strobe_t;

  // Register word addresses below the RAM window
  typedef enum logic [2:0] {
    REG_FIQ_IDX = 3'd0,
    REG_IRQ_IDX = 3'd1,
    REG_FIQ_VEC = 3'd2,
    REG_IRQ_VEC = 3'd3,
    REG_ENABLE  = 3'd4,
    REG_CLASS   = 3'd5
  } ivm_reg_e;

endpackage

// File: rtl/ivm_ctrl.sv
module ivm_ctrl
  import ivm_pkg::*;
#(
  parameter int NUM_CH   = 16,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 7,
  parameter int RAM_BASE = 64,
  parameter int IDX_W    = $clog2(NUM_CH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] reqIn,
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  output ivm_strobe_t       strobe,
  output logic              ramHit,
  output logic [IDX_W-1:0]  ramSlot,
  output logic [IDX_W-1:0]  fiqNextIdx,
  output logic [IDX_W-1:0]  irqNextIdx,
  output logic [IDX_W-1:0]  fiqIdx,
  output logic [IDX_W-1:0]  irqIdx,
  output logic              fiqReq,
  output logic              irqReq,
  output logic [NUM_CH-1:0] enableView,
  output logic [NUM_CH-1:0] classView
);

  localparam logic [ADDR_W-1:0] RAM_LO   = ADDR_W'(RAM_BASE);
  localparam logic [ADDR_W-1:0] RAM_HI   = ADDR_W'(RAM_BASE + NUM_CH);
  localparam logic [ADDR_W-1:0] A_ENABLE = ADDR_W'(REG_ENABLE);
  localparam logic [ADDR_W-1:0] A_CLASS  = ADDR_W'(REG_CLASS);
  localparam logic [NUM_CH-1:0] CH0_MASK = NUM_CH'(1);

  logic [NUM_CH-1:0] reqReg;
  logic [NUM_CH-1:0] enReg;
  logic [NUM_CH-1:0] clsReg;
  logic              phantomSeen;

  logic [NUM_CH-1:0] effEn;
  logic [NUM_CH-1:0] effCls;
  logic [NUM_CH-1:0] activeVec;
  logic [NUM_CH-1:0] fiqCand;
  logic [NUM_CH-1:0] irqCand;

  // Lowest set bit wins; result is bit number plus one, 0 when empty
  function automatic logic [IDX_W-1:0] firstSet(input logic [NUM_CH-1:0] v);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (v[i]) r = IDX_W'(i + 1);
    end
    return r;
  endfunction

  // Channel 0: enable ignored, class forced to fast
  assign effEn     = enReg  | CH0_MASK;
  assign effCls    = clsReg | CH0_MASK;
  assign activeVec = reqReg & effEn;
  assign fiqCand   = activeVec & effCls;
  assign irqCand   = activeVec & ~effCls;

  assign fiqNextIdx = firstSet(fiqCand);
  assign irqNextIdx = firstSet(irqCand);

  assign ramHit  = (busAddr >= RAM_LO) && (busAddr <= RAM_HI);
  assign ramSlot = IDX_W'(busAddr - RAM_LO);

  always_comb begin
    strobe             = '0;
    strobe.ramWe       = busWrEn && ramHit;
    strobe.phantomLoad = busWrEn && ramHit && (ramSlot == '0) && !phantomSeen;
    strobe.loadFiq     = (fiqNextIdx != fiqIdx);
    strobe.loadIrq     = (irqNextIdx != irqIdx);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqReg      <= '0;
      enReg       <= '0;
      clsReg      <= '0;
      phantomSeen <= 1'b0;
      fiqIdx      <= '0;
      irqIdx      <= '0;
      fiqReq      <= 1'b0;
      irqReq      <= 1'b0;
    end else begin
      reqReg <= reqIn;
      fiqIdx <= fiqNextIdx;
      irqIdx <= irqNextIdx;
      fiqReq <= |fiqCand;
      irqReq <= |irqCand;
      if (strobe.phantomLoad) phantomSeen <= 1'b1;
      if (busWrEn && busAddr == A_ENABLE) enReg  <= busWrData[NUM_CH-1:0];
      if (busWrEn && busAddr == A_CLASS)  clsReg <= busWrData[NUM_CH-1:0];
    end
  end

  assign enableView = enReg;
  assign classView  = effCls;

endmodule

// File: rtl/ivm_datapath.sv
module ivm_datapath
  import ivm_pkg::*;
#(
  parameter int NUM_CH = 16,
  parameter int DATA_W = 32,
  parameter int IDX_W  = $clog2(NUM_CH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  ivm_strobe_t       strobe,
  input  logic [IDX_W-1:0]  ramSlot,
  input  logic [DATA_W-1:0] busWrData,
  input  logic [IDX_W-1:0]  fiqNextIdx,
  input  logic [IDX_W-1:0]  irqNextIdx,
  output logic [DATA_W-1:0] ramRdData,
  output logic [DATA_W-1:0] fiqVector,
  output logic [DATA_W-1:0] irqVector
);

  localparam int NUM_SLOTS = NUM_CH + 1;
  localparam int NUM_CLS   = 2;   // 0 = fast, 1 = normal

  logic [DATA_W-1:0] ram [NUM_SLOTS];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int k = 0; k < NUM_SLOTS; k++) ram[k] <= '0;
    end else if (strobe.ramWe) begin
      ram[ramSlot] <= busWrData;
    end
  end

  assign ramRdData = ram[ramSlot];

  logic [IDX_W-1:0]  clsNext [NUM_CLS];
  logic              clsLoad [NUM_CLS];
  logic [DATA_W-1:0] clsVec  [NUM_CLS];

  assign clsNext[0] = fiqNextIdx;
  assign clsNext[1] = irqNextIdx;
  assign clsLoad[0] = strobe.loadFiq;
  assign clsLoad[1] = strobe.loadIrq;

  for (genvar g = 0; g < NUM_CLS; g++) begin : g_cls
    logic [DATA_W-1:0] fwdData;

    // Same-edge RAM write is forwarded into the vector load
    always_comb begin
      if (strobe.ramWe && ramSlot == clsNext[g]) fwdData = busWrData;
      else                                       fwdData = ram[clsNext[g]];
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                   clsVec[g] <= '0;
      else if (clsLoad[g])         clsVec[g] <= fwdData;
      else if (strobe.phantomLoad) clsVec[g] <= busWrData;
    end
  end

  assign fiqVector = clsVec[0];
  assign irqVector = clsVec[1];

endmodule

// File: rtl/intr_vector_mgr.sv
module intr_vector_mgr
  import ivm_pkg::*;
#(
  parameter int NUM_CH   = 16,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 7,
  parameter int RAM_BASE = 64,
  parameter int IDX_W    = $clog2(NUM_CH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] reqIn,
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  output logic              fiqReq,
  output logic              irqReq,
  output logic [IDX_W-1:0]  fiqIndex,
  output logic [IDX_W-1:0]  irqIndex,
  output logic [DATA_W-1:0] fiqVector,
  output logic [DATA_W-1:0] irqVector
);

  localparam logic [ADDR_W-1:0] A_FIQ_IDX = ADDR_W'(REG_FIQ_IDX);
  localparam logic [ADDR_W-1:0] A_IRQ_IDX = ADDR_W'(REG_IRQ_IDX);
  localparam logic [ADDR_W-1:0] A_FIQ_VEC = ADDR_W'(REG_FIQ_VEC);
  localparam logic [ADDR_W-1:0] A_IRQ_VEC = ADDR_W'(REG_IRQ_VEC);
  localparam logic [ADDR_W-1:0] A_ENABLE  = ADDR_W'(REG_ENABLE);
  localparam logic [ADDR_W-1:0] A_CLASS   = ADDR_W'(REG_CLASS);

  ivm_strobe_t       strobe;
  logic              ramHit;
  logic [IDX_W-1:0]  ramSlot;
  logic [IDX_W-1:0]  fiqNextIdx;
  logic [IDX_W-1:0]  irqNextIdx;
  logic [NUM_CH-1:0] enableView;
  logic [NUM_CH-1:0] classView;
  logic [DATA_W-1:0] ramRdData;

  ivm_ctrl #(
    .NUM_CH(NUM_CH), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
    .RAM_BASE(RAM_BASE), .IDX_W(IDX_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .reqIn(reqIn),
    .busWrEn(busWrEn), .busAddr(busAddr), .busWrData(busWrData),
    .strobe(strobe), .ramHit(ramHit), .ramSlot(ramSlot),
    .fiqNextIdx(fiqNextIdx), .irqNextIdx(irqNextIdx),
    .fiqIdx(fiqIndex), .irqIdx(irqIndex),
    .fiqReq(fiqReq), .irqReq(irqReq),
    .enableView(enableView), .classView(classView)
  );

  ivm_datapath #(
    .NUM_CH(NUM_CH), .DATA_W(DATA_W), .IDX_W(IDX_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .ramSlot(ramSlot),
    .busWrData(busWrData), .fiqNextIdx(fiqNextIdx), .irqNextIdx(irqNextIdx),
    .ramRdData(ramRdData), .fiqVector(fiqVector), .irqVector(irqVector)
  );

  always_comb begin
    busRdData = '0;
    if (ramHit) begin
      busRdData = ramRdData;
    end else begin
      case (busAddr)
        A_FIQ_IDX: busRdData = DATA_W'(fiqIndex);
        A_IRQ_IDX: busRdData = DATA_W'(irqIndex);
        A_FIQ_VEC: busRdData = fiqVector;
        A_IRQ_VEC: busRdData = irqVector;
        A_ENABLE:  busRdData = DATA_W'(enableView);
        A_CLASS:   busRdData = DATA_W'(classView);
        default:   busRdData = '0;
      endcase
    end
  end

endmodule

// File: rtl/ivm_checks.sv
module ivm_checks #(
  parameter int NUM_CH   = 16,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 7,
  parameter int RAM_BASE = 64,
  parameter int IDX_W    = $clog2(NUM_CH + 1)
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqCh0,
  input logic              busWrEn,
  input logic [ADDR_W-1:0] busAddr,
  input logic [DATA_W-1:0] busWrData,
  input logic              fiqReq,
  input logic              irqReq,
  input logic [IDX_W-1:0]  fiqIndex,
  input logic [IDX_W-1:0]  irqIndex,
  input logic [DATA_W-1:0] fiqVector,
  input logic [DATA_W-1:0] irqVector
);

  localparam logic [ADDR_W-1:0] SLOT0_ADDR = ADDR_W'(RAM_BASE);
  localparam logic [IDX_W-1:0]  MAX_IDX    = IDX_W'(NUM_CH);

  logic chkSeen;
  logic firstWr;

  assign firstWr = busWrEn && (busAddr == SLOT0_ADDR) && !chkSeen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        chkSeen <= 1'b0;
    else if (firstWr) chkSeen <= 1'b1;
  end

  AST_INDEX_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    (fiqIndex <= MAX_IDX) && (irqIndex <= MAX_IDX)); // R3

  AST_CH0_FAST: assert property (@(posedge clk) disable iff (!rstN)
    reqCh0 |-> ##2 (fiqIndex == IDX_W'(1))); // R2

  AST_CLASS_DISJOINT: assert property (@(posedge clk) disable iff (!rstN)
    (fiqIndex != '0 && irqIndex != '0) |-> (fiqIndex != irqIndex)); // R5

  AST_REQ_LEVEL: assert property (@(posedge clk) disable iff (!rstN)
    (fiqReq == (fiqIndex != '0)) && (irqReq == (irqIndex != '0))); // R10

  AST_PHANTOM_FIQ: assert property (@(posedge clk) disable iff (!rstN)
    firstWr |=> (fiqIndex != $past(fiqIndex)) || (fiqVector == $past(busWrData))); // R8

  AST_PHANTOM_IRQ: assert property (@(posedge clk) disable iff (!rstN)
    firstWr |=> (irqIndex != $past(irqIndex)) || (irqVector == $past(busWrData))); // R8

  AST_VEC_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !firstWr ##1 ($stable(fiqIndex) && $stable(irqIndex))
      |-> ($stable(fiqVector) && $stable(irqVector))); // R7

endmodule

bind intr_vector_mgr ivm_checks #(
  .NUM_CH(NUM_CH), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
  .RAM_BASE(RAM_BASE), .IDX_W(IDX_W)
) u_checks (
  .clk(clk), .rstN(rstN), .reqCh0(reqIn[0]),
  .busWrEn(busWrEn), .busAddr(busAddr), .busWrData(busWrData),
  .fiqReq(fiqReq), .irqReq(irqReq),
  .fiqIndex(fiqIndex), .irqIndex(irqIndex),
  .fiqVector(fiqVector), .irqVector(irqVector)
);

// File: tb/intr_vector_mgr_bench.sv
module intr_vector_mgr_bench;

  localparam int NUM_CH = 16;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 7;
  localparam int BASE   = 64;
  localparam int IDX_W  = 5;

  localparam logic [31:0] PH  = 32'hDEAD_0000;
  localparam logic [31:0] PH2 = 32'hDEAD_0004;
  localparam logic [31:0] HV  = 32'h0000_0A00;
  localparam logic [31:0] NEWV = 32'h0000_7770;

  logic              clk = 1'b0;
  logic              rstN;
  logic [NUM_CH-1:0] reqIn;
  logic              busWrEn;
  logic [ADDR_W-1:0] busAddr;
  logic [DATA_W-1:0] busWrData;
  logic [DATA_W-1:0] busRdData;
  logic              fiqReq, irqReq;
  logic [IDX_W-1:0]  fiqIndex, irqIndex;
  logic [DATA_W-1:0] fiqVector, irqVector;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  intr_vector_mgr u_intr_vector_mgr (
    .clk(clk), .rstN(rstN), .reqIn(reqIn),
    .busWrEn(busWrEn), .busAddr(busAddr), .busWrData(busWrData),
    .busRdData(busRdData), .fiqReq(fiqReq), .irqReq(irqReq),
    .fiqIndex(fiqIndex), .irqIndex(irqIndex),
    .fiqVector(fiqVector), .irqVector(irqVector)
  );

  function automatic logic [31:0] vecOf(input int k);
    return 32'h0000_1000 + 32'(k * 16);
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Drive at a negedge, latched at the following posedge
  task automatic busWrite(input int addr, input logic [31:0] data);
    busWrEn = 1'b1; busAddr = ADDR_W'(addr); busWrData = data;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic busRead(input int addr, output logic [31:0] data);
    busAddr = ADDR_W'(addr);
    #1 data = busRdData;
  endtask

  // Request sampled at next posedge, index updates one edge later
  task automatic setReq(input logic [NUM_CH-1:0] v);
    reqIn = v;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset_state;
    chk("R1", "fiqIndex", 32'(fiqIndex), 0);
    chk("R1", "irqIndex", 32'(irqIndex), 0);
    chk("R1", "fiqReq", 32'(fiqReq), 0);
    chk("R1", "fiqVector", fiqVector, 0);
    chk("R1", "irqVector", irqVector, 0);
  endtask

  task automatic t_phantom_quirk;
    logic [31:0] rd;
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk("R2", "ch0 pending at reset, fiqIndex", 32'(fiqIndex), 1);
    chk("R10", "fiqReq", 32'(fiqReq), 1);
    chk("R7", "vector from unwritten RAM", fiqVector, 0);
    chk("R3", "irqIndex idle", 32'(irqIndex), 0);
    busWrite(BASE + 0, PH);
    chk("R8", "first slot0 write fiqVector", fiqVector, PH);
    chk("R8", "first slot0 write irqVector", irqVector, PH);
    chk("R8", "fiqIndex unchanged", 32'(fiqIndex), 1);
    busWrite(BASE + 1, HV);
    chk("R7", "no reload while index stable", fiqVector, PH);
    busWrite(BASE + 0, PH2);
    chk("R8", "second slot0 write fiqVector", fiqVector, PH);
    chk("R8", "second slot0 write irqVector", irqVector, PH);
    busRead(BASE + 0, rd);
    chk("R11", "slot0 readback", rd, PH2);
    setReq('0);
    chk("R3", "fiqIndex none", 32'(fiqIndex), 0);
    chk("R10", "fiqReq low", 32'(fiqReq), 0);
    chk("R7", "phantom on idle", fiqVector, PH2);
    setReq(NUM_CH'(1));
    chk("R7", "ch0 vector reload", fiqVector, HV);
    setReq('0);
  endtask

  task automatic t_program;
    logic [31:0] rd;
    for (int k = 1; k <= NUM_CH; k++) busWrite(BASE + k, vecOf(k));
    busWrite(4, 32'h0000_FFFF);
    busWrite(5, 32'h0000_FF00);
    busRead(5, rd);
    chk("R5", "class reads bit0 set", rd, 32'h0000_FF01);
    busRead(4, rd);
    chk("R11", "enable readback", rd, 32'h0000_FFFF);
    busRead(BASE + 7, rd);
    chk("R11", "slot7 readback", rd, vecOf(7));
  endtask

  task automatic t_priority;
    setReq(NUM_CH'((1 << 3) | (1 << 5)));
    chk("R4", "irqIndex lowest of 3,5", 32'(irqIndex), 4);
    chk("R7", "irqVector slot4", irqVector, vecOf(4));
    chk("R5", "fiqIndex idle", 32'(fiqIndex), 0);
    setReq(NUM_CH'(1 << 5));
    chk("R4", "irqIndex ch5", 32'(irqIndex), 6);
    chk("R7", "irqVector slot6", irqVector, vecOf(6));
    setReq(NUM_CH'((1 << 9) | (1 << 12) | (1 << 2)));
    chk("R4", "fiqIndex lowest of 9,12", 32'(fiqIndex), 10);
    chk("R7", "fiqVector slot10", fiqVector, vecOf(10));
    chk("R5", "ch2 in normal class", 32'(irqIndex), 3);
    setReq(NUM_CH'((1 << 9) | (1 << 12) | (1 << 2) | 1));
    chk("R4", "ch0 beats ch9", 32'(fiqIndex), 1);
    chk("R7", "fiqVector slot1", fiqVector, vecOf(1));
    setReq('0);
    chk("R7", "irqVector phantom", irqVector, PH2);
    chk("R10", "irqReq low", 32'(irqReq), 0);
  endtask

  task automatic t_enable_class;
    logic [31:0] rd;
    busWrite(4, 32'h0000_FFF6);
    setReq(NUM_CH'(1 << 3));
    chk("R6", "disabled ch3 irqIndex", 32'(irqIndex), 0);
    chk("R6", "disabled ch3 irqReq", 32'(irqReq), 0);
    setReq(NUM_CH'((1 << 3) | (1 << 4)));
    chk("R6", "ch4 wins over disabled ch3", 32'(irqIndex), 5);
    setReq(NUM_CH'(1));
    chk("R2", "ch0 with enable bit clear", 32'(fiqIndex), 1);
    busWrite(5, 32'h0000_FF00);
    repeat (2) @(negedge clk);
    chk("R2", "ch0 class bit cleared fiqIndex", 32'(fiqIndex), 1);
    chk("R2", "ch0 class bit cleared irqIndex", 32'(irqIndex), 0);
    busRead(5, rd);
    chk("R5", "class bit0 reads 1", rd, 32'h0000_FF01);
    setReq('0);
    busWrite(5, 32'h0000_0000);
    setReq(NUM_CH'(1 << 9));
    chk("R5", "ch9 moved to normal", 32'(irqIndex), 10);
    chk("R5", "fast idle", 32'(fiqIndex), 0);
    setReq('0);
  endtask

  task automatic t_forward;
    logic [31:0] rd;
    reqIn = NUM_CH'(1 << 2);
    @(negedge clk);
    busWrite(BASE + 3, NEWV);
    chk("R9", "irqIndex", 32'(irqIndex), 3);
    chk("R9", "forwarded irqVector", irqVector, NEWV);
    busRead(1, rd);
    chk("R11", "irq index reg", rd, 3);
    busRead(3, rd);
    chk("R11", "irq vector reg", rd, NEWV);
    busRead(0, rd);
    chk("R11", "fiq index reg", rd, 0);
    setReq('0);
  endtask

  task automatic t_rereset;
    logic [31:0] rd;
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    busRead(4, rd);
    chk("R1", "enable cleared", rd, 0);
    busRead(BASE + 5, rd);
    chk("R1", "RAM cleared", rd, 0);
    rstN = 1'b1;
    @(negedge clk);
    busWrite(BASE + 0, 32'hBEEF_0000);
    chk("R8", "first write after new reset", irqVector, 32'hBEEF_0000);
    chk("R8", "first write after new reset fiq", fiqVector, 32'hBEEF_0000);
    busWrite(BASE + 0, 32'hBEEF_1111);
    chk("R8", "later write ignored", irqVector, 32'hBEEF_0000);
  endtask

  initial begin
    rstN = 1'b0; reqIn = NUM_CH'(1);
    busWrEn = 1'b0; busAddr = '0; busWrData = '0;
    repeat (3) @(negedge clk);
    t_reset_state();
    t_phantom_quirk();
    t_program();
    t_priority();
    t_enable_class();
    t_forward();
    t_rereset();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule